// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

This block shifts a 32-bit word by any distance from 0 to 31 in a single pass of combinational logic. It is built as a chain of fixed multiplexer stages. Each stage moves the word by one power of two, and each stage is switched on by one bit of the shift distance. The chain has no data-dependent loop bounds: the number of stages is set at elaboration, and every stage always exists in hardware.

There is only one shifting core, and it shifts toward the most-significant end. A right shift mirrors the bit order of the word before the core, shifts left, and then mirrors the result back. The operating mode decides only which bit is fed into the vacated positions. In logical mode that bit is zero. In arithmetic right mode it is the sign bit of the input.

Typical use is as the shift path of a datapath. The parent block registers the result as it needs.

Top module: `barrel_shift_unit`

## Requirements
- R1: When the shift distance is 0, the output equals the input in every combination of direction and mode.
- R2: With the direction input at 1 (left) and the mode input at 1 (logical), the output is the input moved toward the most-significant end by the shift distance, with zeros in the vacated low positions.
- R3: With the direction input at 1 (left) and the mode input at 0 (arithmetic), the output is identical to the logical left result for the same word and distance.
- R4: With the direction input at 0 (right) and the mode input at 1 (logical), the output is the input moved toward the least-significant end by the shift distance, with zeros in the vacated high positions.
- R5: With the direction input at 0 (right) and the mode input at 0 (arithmetic), the vacated high positions and the top bit of the output all copy bit 31 of the input, and the remaining bits equal the logical right result.
- R6: Shift-distance bit k moves the word by 2^k positions, independently of the other bits. For example, a distance of 5 (binary 00101) equals a shift by 1 followed by a shift by 4.
- R7: The output follows any input change with no clock edge involved. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to be shifted |
| shamt | input | 5 | Shift distance, 0 to 31 |
| dir_left | input | 1 | 1 selects a left shift, 0 selects a right shift |
| mode_logical | input | 1 | 1 selects zero fill, 0 selects sign fill on right shifts |
| data_out | output | 32 | Shifted word |

## Verification
The checker takes it for granted that every input carries a defined 0 or 1 level; with unknown bits the fill and mask relations cannot hold. The 5-bit distance can never exceed the word width, so no input range has to be excluded. The stimulus drives only fully defined values from tasks. It waits a short settle time after each change before the output is compared against a shift computed in the bench.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;

    localparam int DEF_WIDTH = 32;

    // Steering for one pass through the shared left-shifting core
    typedef struct packed {
        logic mirror;   // 1: reverse bit order around the core
        logic fill;     // value entering vacated positions
    } steer_t;

endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec_in,
    output logic [WIDTH-1:0] vec_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_swap
        assign vec_out[i] = vec_in[WIDTH-1-i];
    end

endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] stage_in,
    input  logic             enable,
    input  logic             fill,
    output logic [WIDTH-1:0] stage_out
);

    logic [WIDTH-1:0] moved;

    assign moved     = {stage_in[WIDTH-1-DIST:0], {DIST{fill}}};
    assign stage_out = enable ? moved : stage_in;

endmodule

// File: rtl/left_shift_core.sv
module left_shift_core #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word_in,
    input  logic [AMT_W-1:0] amount,
    input  logic             fill,
    output logic [WIDTH-1:0] word_out
);

    logic [WIDTH-1:0] tap [AMT_W+1];

    assign tap[0] = word_in;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        shift_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) u_stage (
            .stage_in  (tap[k]),
            .enable    (amount[k]),
            .fill      (fill),
            .stage_out (tap[k+1])
        );
    end

    assign word_out = tap[AMT_W];

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import barrel_shift_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] shamt,
    input  logic             dir_left,
    input  logic             mode_logical,
    output logic [WIDTH-1:0] data_out
);

    steer_t           steer_d;
    logic [WIDTH-1:0] in_mirrored;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] out_mirrored;

    always_comb begin
        steer_d        = '0;
        steer_d.mirror = ~dir_left;
        // sign fill only for right arithmetic; left always fills zeros
        steer_d.fill   = ~dir_left & ~mode_logical & data_in[WIDTH-1];
    end

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_in (
        .vec_in  (data_in),
        .vec_out (in_mirrored)
    );

    assign core_in = steer_d.mirror ? in_mirrored : data_in;

    left_shift_core #(.WIDTH(WIDTH)) u_core (
        .word_in  (core_in),
        .amount   (shamt),
        .fill     (steer_d.fill),
        .word_out (core_out)
    );

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_out (
        .vec_in  (core_out),
        .vec_out (out_mirrored)
    );

    assign data_out = steer_d.mirror ? out_mirrored : core_out;

endmodule

// File: rtl/barrel_shift_check.sv
module barrel_shift_check #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] shamt,
    input  logic             dir_left,
    input  logic             mode_logical,
    input  logic [WIDTH-1:0] data_out
);

    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;

    always_comb begin
        low_mask  = ({{(WIDTH-1){1'b0}}, 1'b1} << shamt) - 1'b1;
        high_mask = ~({WIDTH{1'b1}} >> shamt);

        AST_ZERO_DIST_PASS: assert (shamt != '0 || data_out == data_in); // R1
        AST_LEFT_LOW_ZERO: assert (!dir_left || (data_out & low_mask) == '0); // R2
        AST_LEFT_NO_GAIN: assert (!dir_left || $countones(data_out) <= $countones(data_in)); // R3
        AST_RLOG_HIGH_ZERO: assert (dir_left || !mode_logical || (data_out & high_mask) == '0); // R4
        AST_RARI_SIGN_FILL: assert (dir_left || mode_logical
            || (data_out & high_mask) == ({WIDTH{data_in[WIDTH-1]}} & high_mask)); // R5
        AST_RARI_TOP_KEPT: assert (dir_left || mode_logical
            || data_out[WIDTH-1] == data_in[WIDTH-1]); // R5
    end

endmodule

bind barrel_shift_unit barrel_shift_check #(.WIDTH(WIDTH)) u_check (
    .data_in      (data_in),
    .shamt        (shamt),
    .dir_left     (dir_left),
    .mode_logical (mode_logical),
    .data_out     (data_out)
);

// File: tb/barrel_shift_unit_test.sv
`timescale 1ns/1ps
module barrel_shift_unit_test;

    localparam int W = 32;
    localparam int A = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [A-1:0] shamt = '0;
    logic         dir_left = 1'b1;
    logic         mode_logical = 1'b1;
    logic [W-1:0] data_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    barrel_shift_unit uut (
        .data_in      (data_in),
        .shamt        (shamt),
        .dir_left     (dir_left),
        .mode_logical (mode_logical),
        .data_out     (data_out)
    );

    function automatic logic [W-1:0] expect_shift(input logic [W-1:0] v, input int n,
                                                  input logic left, input logic logical);
        logic [W-1:0] r;
        if (left)         r = v << n;
        else if (logical) r = v >> n;
        else              r = W'($signed(v) >>> n);
        return r;
    endfunction

    task automatic compare(input string req, input logic [W-1:0] exp_v);
        checks++;
        if (data_out !== exp_v) begin
            errors++;
            $display("FAIL %s din=%h amt=%0d left=%b logical=%b got=%h exp=%h",
                     req, data_in, shamt, dir_left, mode_logical, data_out, exp_v);
        end
    endtask

    task automatic apply(input logic [W-1:0] v, input int n, input logic left, input logic logical);
        data_in = v; shamt = A'(n); dir_left = left; mode_logical = logical;
        #1;
    endtask

    task automatic check_all(input logic [W-1:0] v, input int n, input logic left,
                             input logic logical, input string req);
        apply(v, n, left, logical);
        compare(req, expect_shift(v, n, left, logical));
    endtask

    // R7: idle state and output response without any clock edge
    task automatic t_idle;
        apply('0, 0, 1'b1, 1'b1);
        compare("R7", '0);
        data_in = 32'h0000_00F0;
        #1;
        compare("R7", 32'h0000_00F0);
        shamt = 5'd4;
        #1;
        compare("R7", 32'h0000_0F00);
    endtask

    task automatic t_zero_distance;
        for (int m = 0; m < 4; m++) begin
            apply(32'hA5C3_1E87, 0, m[1], m[0]);
            compare("R1", 32'hA5C3_1E87);
            apply(32'h8000_0001, 0, m[1], m[0]);
            compare("R1", 32'h8000_0001);
        end
    endtask

    task automatic t_left;
        apply(32'h0000_0001, 31, 1'b1, 1'b1); compare("R2", 32'h8000_0000);
        apply(32'hFFFF_FFFF, 8, 1'b1, 1'b1);  compare("R2", 32'hFFFF_FF00);
        apply(32'h8000_0000, 1, 1'b1, 1'b1);  compare("R2", 32'h0000_0000);
        apply(32'hFFFF_FFFF, 8, 1'b1, 1'b0);  compare("R3", 32'hFFFF_FF00);
        apply(32'h8000_0001, 3, 1'b1, 1'b0);  compare("R3", 32'h0000_0008);
    endtask

    task automatic t_right_logical;
        apply(32'h8000_0000, 31, 1'b0, 1'b1); compare("R4", 32'h0000_0001);
        apply(32'hFFFF_FFFF, 4, 1'b0, 1'b1);  compare("R4", 32'h0FFF_FFFF);
        apply(32'h0000_0001, 1, 1'b0, 1'b1);  compare("R4", 32'h0000_0000);
    endtask

    task automatic t_right_arith;
        apply(32'h8000_0000, 31, 1'b0, 1'b0); compare("R5", 32'hFFFF_FFFF);
        apply(32'h8000_0000, 4, 1'b0, 1'b0);  compare("R5", 32'hF800_0000);
        apply(32'h7000_0000, 4, 1'b0, 1'b0);  compare("R5", 32'h0700_0000);
        apply(32'hFFFF_FFFF, 17, 1'b0, 1'b0); compare("R5", 32'hFFFF_FFFF);
    endtask

    task automatic t_stage_bits;
        // R6: distance 5 uses the 1- and 4-position stages together
        apply(32'h0000_0003, 5, 1'b1, 1'b1);  compare("R6", 32'h0000_0060);
        apply(32'hC000_0000, 5, 1'b0, 1'b1);  compare("R6", 32'h0600_0000);
        for (int k = 0; k < A; k++) begin
            apply(32'h0000_0001, 1 << k, 1'b1, 1'b1);
            compare("R6", 32'h1 << (1 << k));
        end
    endtask

    task automatic t_sweep;
        logic [W-1:0] pats [5];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h8000_0000;
        pats[2] = 32'h0000_0001;
        pats[3] = $urandom;
        pats[4] = $urandom | 32'h8000_0000;
        for (int p = 0; p < 5; p++) begin
            for (int n = 0; n < W; n++) begin
                check_all(pats[p], n, 1'b1, 1'b1, "R2");
                check_all(pats[p], n, 1'b1, 1'b0, "R3");
                check_all(pats[p], n, 1'b0, 1'b1, "R4");
                check_all(pats[p], n, 1'b0, 1'b0, "R5");
            end
        end
    endtask

    initial begin
        #25 rst_n = 1'b1;
        t_idle();
        t_zero_distance();
        t_left();
        t_right_logical();
        t_right_arith();
        t_stage_bits();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule